// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block wraps a small fixed combinational function with a chain of multiplexed-input scan flip-flops. A sequencer runs a complete scan test from a single start pulse. For each pattern it shifts a stimulus vector into the chain serially. It then drops scan enable for one clock so that every cell stores the output of the logic under test. The next shift phase moves that response out through the scan-out pin while the next stimulus moves in.

The caller streams the stimulus on one serial input and the matching known-good response on a second serial input, both on the same clocks. The block compares each bit as it leaves the chain. It keeps a sticky mismatch flag and pulses a done signal once the final response has left the chain. A fault-injection input inverts one internal node of the logic, so the comparison path can be shown to fire.

Top module: `scan_seq_top`

## Requirements
- R1: Each cell has a two-way input select. With scan enable high the cell takes its chain neighbour (cell 0 takes `scanIn`). With scan enable low it takes its functional input. The cell holds its value while the sequencer is idle.
- R2: Cell i feeds cell i+1 and `scanOut` is the last cell, N-1. In each shift phase the first stimulus bit ends in cell N-1, and the response bits leave in the order cell N-1, N-2, …, 0.
- R3: Take the clock edge that samples `start` in idle as edge 0. The sequencer then runs PATTERNS times N shift edges, each group followed by one capture edge, and then a final group of N shift edges. Each response unload overlaps the next stimulus load.
- R4: Between two shift phases scan enable is low for exactly one clock, the capture clock. It changes only at clock edges.
- R5: The logic under test gives f[i] = q[(i+1) mod N] XOR (q[i] AND q[(i+2) mod N]). When `faultEn` is high, f[0] is inverted.
- R6: During every shift of phases 1..PATTERNS, `scanOut` is compared with `expIn`, and any difference sets `mismatch`. No comparison is made while the first stimulus is loaded or during capture.
- R7: `mismatch` is sticky. Only a start that is accepted in idle clears it, and it is low in the cycle after that start edge.
- R8: `done` is high for exactly one cycle, the cycle right after the final shift edge, which is edge PATTERNS*(N+1)+N.
- R9: A `start` pulse that arrives while a test is running is ignored. It does not disturb the timing of `done` and does not clear `mismatch`.
- R10: A synchronous active-high `rst` returns the sequencer to idle with scan enable low, counters cleared, and `done` and `mismatch` low. Cell contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a test run when sampled high in idle |
| scanIn | input | 1 | Serial stimulus bit |
| expIn | input | 1 | Serial expected-response bit, aligned with the unload shift |
| faultEn | input | 1 | Inverts node f[0] of the logic under test |
| scanOut | output | 1 | Last cell of the chain |
| done | output | 1 | One-cycle pulse after the final unload shift |
| mismatch | output | 1 | Sticky response-compare failure flag |

## Verification
The assertions check the sequencing on every cycle. Shift and capture never coincide, a capture is always single and always follows a shift, `done` is a single-cycle pulse that follows a shift, and `mismatch` only rises while a compare is enabled, stays set, and falls only after an accepted start. The bench scenarios cover the remaining behaviour. They check the bit order through the chain, the captured value of the logic function with and without the injected fault, the exact cycle of `done`, and the effect of a wrong expected bit at the first and last unload position. They also check that a stray start during a run is ignored.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2
  } seqState_t;

  // Strobes from the sequencer to the chain datapath
  typedef struct packed {
    logic shiftEn;   // scan enable: chain moves one place
    logic captureEn; // functional capture clock
    logic cmpEn;     // compare scanOut against expIn this cycle
    logic clrMis;    // clear the sticky mismatch flag
  } scanStrobe_t;

endpackage

// File: rtl/scan_cut_logic.sv
module scan_cut_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cellQ,
  input  logic             faultEn,
  output logic [WIDTH-1:0] funcOut
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_node
    logic node;
    assign node = cellQ[(i + 1) % WIDTH] ^ (cellQ[i] & cellQ[(i + 2) % WIDTH]);
    if (i == 0) begin : g_fault
      assign funcOut[i] = node ^ faultEn;
    end else begin : g_clean
      assign funcOut[i] = node;
    end
  end

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PATTERNS  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output scanStrobe_t str,
  output logic        done
);

  localparam int BIT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam int PAT_W = $clog2(PATTERNS + 1) + 1;

  seqState_t        state;
  logic [BIT_W-1:0] bitCnt;
  logic [PAT_W-1:0] patCnt;
  logic             lastBit;
  logic             lastPat;

  assign lastBit = (bitCnt == BIT_W'(CHAIN_LEN - 1));
  assign lastPat = (patCnt == PAT_W'(PATTERNS));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      patCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SHIFT;
            bitCnt <= '0;
            patCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (lastBit) begin
            bitCnt <= '0;
            if (lastPat) begin
              state  <= ST_IDLE;
              patCnt <= '0;
              done   <= 1'b1;
            end else begin
              state <= ST_CAPT;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_CAPT: begin
          patCnt <= patCnt + 1'b1;
          state  <= ST_SHIFT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    str.shiftEn   = (state == ST_SHIFT);
    str.captureEn = (state == ST_CAPT);
    str.cmpEn     = (state == ST_SHIFT) && (patCnt != '0);
    str.clrMis    = (state == ST_IDLE) && start;
  end

  AST_SHIFT_CAPT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(str.shiftEn && str.captureEn)); // R1
  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    str.captureEn |=> (!str.captureEn && str.shiftEn)); // R4
  AST_CAPT_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
    str.captureEn |-> $past(str.shiftEn)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(str.shiftEn) && !str.shiftEn && !str.captureEn)); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!str.shiftEn && !str.captureEn && !done)); // R10
  AST_NO_CMP_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(str.shiftEn) && !$past(str.captureEn) |-> !str.cmpEn); // R6

endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  scanStrobe_t str,
  input  logic        scanIn,
  input  logic        expIn,
  input  logic        faultEn,
  output logic        scanOut,
  output logic        mismatch
);

  logic [CHAIN_LEN-1:0] cellQ;
  logic [CHAIN_LEN-1:0] funcOut;
  logic [CHAIN_LEN-1:0] chainIn;

  scan_cut_logic #(.WIDTH(CHAIN_LEN)) u_cut (
    .cellQ   (cellQ),
    .faultEn (faultEn),
    .funcOut (funcOut)
  );

  // One mux-D scan cell per chain position
  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    logic cellD;
    if (i == 0) begin : g_head
      assign chainIn[i] = scanIn;
    end else begin : g_body
      assign chainIn[i] = cellQ[i-1];
    end
    assign cellD = str.shiftEn ? chainIn[i] : funcOut[i];
    always_ff @(posedge clk) begin
      if (str.shiftEn || str.captureEn) cellQ[i] <= cellD;
    end
  end

  assign scanOut = cellQ[CHAIN_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mismatch <= 1'b0;
    end else if (str.clrMis) begin
      mismatch <= 1'b0;
    end else if (str.cmpEn && (scanOut != expIn)) begin
      mismatch <= 1'b1;
    end
  end

  AST_MIS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mismatch && !str.clrMis) |=> mismatch); // R7
  AST_MIS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    str.clrMis |=> !mismatch); // R7
  AST_MIS_ONLY_CMP: assert property (@(posedge clk) disable iff (rst)
    $rose(mismatch) |-> $past(str.cmpEn)); // R6

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PATTERNS  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic scanIn,
  input  logic expIn,
  input  logic faultEn,
  output logic scanOut,
  output logic done,
  output logic mismatch
);

  scanStrobe_t str;

  scan_seq_ctrl #(.CHAIN_LEN(CHAIN_LEN), .PATTERNS(PATTERNS)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .str   (str),
    .done  (done)
  );

  scan_seq_dp #(.CHAIN_LEN(CHAIN_LEN)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .str      (str),
    .scanIn   (scanIn),
    .expIn    (expIn),
    .faultEn  (faultEn),
    .scanOut  (scanOut),
    .mismatch (mismatch)
  );

endmodule

// File: tb/scan_seq_top_tb.sv
module scan_seq_top_tb;

  localparam int N   = 8;
  localparam int PAT = 4;

  logic clk = 1'b0;
  logic rst, start, scanIn, expIn, faultEn;
  logic scanOut, done, mismatch;

  int nCheck = 0;
  int nFail  = 0;
  int cyc    = 0;

  scan_seq_top #(.CHAIN_LEN(N), .PATTERNS(PAT)) u_dut (
    .clk(clk), .rst(rst), .start(start), .scanIn(scanIn), .expIn(expIn),
    .faultEn(faultEn), .scanOut(scanOut), .done(done), .mismatch(mismatch)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R5 function, written from the requirement
  function automatic logic [N-1:0] cutFn(input logic [N-1:0] q, input logic flt);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = q[(i+1)%N] ^ (q[i] & q[(i+2)%N]);
    r[0] = r[0] ^ flt;
    return r;
  endfunction

  // vecMode: 0 random, 1 all zero, 2 all one
  task automatic runTest(input int vecMode, input logic flt, input int flipPh,
                         input int flipB, input int strayPh);
    logic [N-1:0] mDut  = '0;
    logic [N-1:0] mGood = '0;
    logic expMis = 1'b0;
    logic vb, outBit, eb;
    @(negedge clk);
    faultEn = flt;
    start   = 1'b1;
    for (int ph = 0; ph <= PAT; ph++) begin
      for (int b = 0; b < N; b++) begin
        @(negedge clk);
        start = (ph == strayPh) && (b == 2); // R9 stray start while busy
        if (ph == PAT) vb = 1'b0;
        else if (vecMode == 1) vb = 1'b0;
        else if (vecMode == 2) vb = 1'b1;
        else vb = 1'($urandom);
        if (ph == 0 && b == 0) check(mismatch == 1'b0, "R7 clear on start", 32'(mismatch), 0);
        if (ph == PAT && b == N-1) check(done == 1'b0, "R8 done early", 32'(done), 0);
        if (ph > 0) begin
          outBit = mDut[N-1];
          check(scanOut == outBit, "R2/R5 scanOut bit", 32'(scanOut), 32'(outBit));
          eb = mGood[N-1] ^ ((ph == flipPh) && (b == flipB));
          if (eb != outBit) expMis = 1'b1;
          expIn = eb;
        end else begin
          expIn = 1'b0;
        end
        scanIn = vb;
        mDut   = {mDut[N-2:0], vb};
        mGood  = {mGood[N-2:0], vb};
      end
      if (ph < PAT) begin
        @(negedge clk); // capture cycle, R4
        start = 1'b0;
        mDut  = cutFn(mDut, flt);
        mGood = cutFn(mGood, 1'b0);
      end
    end
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R8 done pulse", 32'(done), 1);
    check(mismatch == expMis, "R6 mismatch result", 32'(mismatch), 32'(expMis));
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", 32'(done), 0);
    check(mismatch == expMis, "R7 sticky in idle", 32'(mismatch), 32'(expMis));
    repeat (3) @(negedge clk);
    check(mismatch == expMis, "R7 sticky hold", 32'(mismatch), 32'(expMis));
    faultEn = 1'b0;
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'd5113);
    rst = 1'b1; start = 1'b0; scanIn = 1'b0; expIn = 1'b0; faultEn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R10 reset done", 32'(done), 0);
    check(mismatch == 1'b0, "R10 reset mismatch", 32'(mismatch), 0);

    runTest(0, 1'b0, -1, 0, -1);      // R1 R3 random, clean
    runTest(1, 1'b0, -1, 0, -1);      // all zero vectors
    runTest(2, 1'b0, -1, 0, -1);      // all one vectors
    runTest(0, 1'b0, 1, 0, -1);       // R6 wrong first unload bit
    runTest(0, 1'b0, -1, 0, -1);      // R7 cleared by next start
    runTest(0, 1'b1, -1, 0, -1);      // R5 injected fault caught
    runTest(0, 1'b0, 1, 3, 3);        // R9 stray start keeps mismatch
    runTest(0, 1'b0, PAT, N-1, -1);   // R6 wrong last unload bit
    for (int k = 0; k < 4; k++) runTest(0, 1'b0, -1, 0, (k == 1) ? 2 : -1);

    // R10 reset mid-run returns to idle
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (N * 2) begin
      @(negedge clk);
      check(done == 1'b0, "R10 idle after reset", 32'(done), 0);
    end
    check(mismatch == 1'b0, "R10 mismatch after reset", 32'(mismatch), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

endmodule